// File: doc/BRIEF.md
# Event Duration and Count Accumulator

This block watches one asynchronous event line and keeps two running totals: the accumulated time the line has been high, in quarter-second units, and the number of completed events. Both totals saturate at their maximum instead of wrapping. Time is measured against a free-running timebase tick. Every duration is a parameter counted in ticks, so the block can be scaled from real time down to short simulation values.

At each qualified rising edge of the event, the counters take the values offered on the preload ports, which hold the previously saved totals. A short busy window then covers that restore. While the event stays high, the first quarter-second is credited half a period after the edge and later ones every full period. When the event ends, the event count steps. A one-cycle commit strobe then tells the surrounding logic to save both totals, and the busy flag covers the save time. A clear strobe zeroes both totals unless the lock input is high.

Top module: `evt_tally`

## Requirements
- R1: The raw event passes through a two-flop synchronizer and a filter. A level change must be seen on GLITCH_TICKS consecutive ticks before it counts. A high pulse that spans fewer ticks changes neither total, gives no commit and gives no busy.
- R2: In the cycle after a qualified rising edge, the time total equals `load_time` and the event total equals `load_count`. `busy` is then high for exactly XFER_TICKS ticks.
- R3: An event that stays high for H ticks, with H at least START_TICKS, adds 1 + (H - START_TICKS) / INCR_TICKS to the time total. The first step comes START_TICKS ticks after the qualified edge and the later steps come every INCR_TICKS ticks.
- R4: An event with H at least GLITCH_TICKS but below START_TICKS adds nothing to the time total. It still counts as an event.
- R5: The event total steps by one at each qualified falling edge and changes at no other time, except through preload or clear.
- R6: The time total holds at all ones (FFFFFFFFh at the default width) and never wraps.
- R7: The event total holds at 1FFFFh and never wraps.
- R8: Each qualified falling edge produces exactly one `commit` pulse, one cycle wide. The pulse comes after both totals have taken their final values for that event.
- R9: From the cycle of `commit`, `busy` is high for exactly WRITE_TICKS ticks.
- R10: With `lock` low, a one-cycle `clr` zeroes both totals in the next cycle. With `lock` high, `clr` leaves both totals unchanged.
- R11: After reset both totals are zero and `commit` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| evt_raw | input | 1 | Asynchronous raw event line |
| load_time | input | TIME_W | Time total restored at event start |
| load_count | input | CNT_W | Event total restored at event start |
| clr | input | 1 | Clear strobe for both totals |
| lock | input | 1 | High blocks `clr` |
| time_q | output | TIME_W | Live elapsed-time total |
| count_q | output | CNT_W | Live event total |
| commit | output | 1 | One-cycle save request at event end |
| busy | output | 1 | Restore or save window in progress |

## Verification
A filter that misses or invents edges shows up at the ports within one event: the commit count or the busy-tick count differs from expected once the line has been low for GLITCH_TICKS ticks. A wrong phase in the increment pacer shows up at event end as a time total that is off by one. Events whose lengths fall exactly on the half-period and full-period boundaries expose that error. A saturation fault appears only after the total has been preloaded next to its limit. In that case it shows as a small wrapped value when the event that follows ends.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } evt_edge_t;
endpackage

// File: rtl/evt_deglitch.sv
module evt_deglitch
  import evt_tally_pkg::*;
#(
  parameter int GLITCH_TICKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      raw,
  output evt_edge_t ev
);
  localparam int GW = $clog2(GLITCH_TICKS + 1);

  logic          s1_q, s2_q;
  logic          lvl_q, lvl_d;
  logic          rise_q, rise_d, fall_q, fall_d;
  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == GW'(GLITCH_TICKS - 1)) begin
        lvl_d  = s2_q;
        cnt_d  = '0;
        rise_d = s2_q;
        fall_d = ~s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign ev.level = lvl_q;
  assign ev.rise  = rise_q;
  assign ev.fall  = fall_q;
endmodule

// File: rtl/evt_pacer.sv
module evt_pacer #(
  parameter int START_TICKS = 5,
  parameter int INCR_TICKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic restart,
  output logic inc
);
  localparam int PMAX = (START_TICKS > INCR_TICKS) ? START_TICKS : INCR_TICKS;
  localparam int PW   = $clog2(PMAX + 1);

  logic          first_q, first_d;
  logic          inc_q, inc_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] limit;

  assign limit = first_q ? PW'(START_TICKS - 1) : PW'(INCR_TICKS - 1);

  always_comb begin
    first_d = first_q;
    pcnt_d  = pcnt_q;
    inc_d   = 1'b0;
    if (restart) begin
      first_d = 1'b1;
      pcnt_d  = '0;
    end else if (active && tick) begin
      if (pcnt_q == limit) begin
        inc_d   = 1'b1;
        pcnt_d  = '0;
        first_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      pcnt_q  <= '0;
      inc_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      pcnt_q  <= pcnt_d;
      inc_q   <= inc_d;
    end
  end

  assign inc = inc_q;
endmodule

// File: rtl/evt_busy.sv
module evt_busy #(
  parameter int WRITE_TICKS = 6,
  parameter int XFER_TICKS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_xfer,
  input  logic start_write,
  output logic busy
);
  localparam int BMAX = (WRITE_TICKS > XFER_TICKS) ? WRITE_TICKS : XFER_TICKS;
  localparam int BW   = $clog2(BMAX + 1);

  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_write)              cnt_d = BW'(WRITE_TICKS);
    else if (start_xfer)          cnt_d = BW'(XFER_TICKS);
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/evt_tally.sv
module evt_tally
  import evt_tally_pkg::*;
#(
  parameter int TIME_W       = 32,
  parameter int CNT_W        = 17,
  parameter int GLITCH_TICKS = 4,
  parameter int START_TICKS  = 5,
  parameter int INCR_TICKS   = 10,
  parameter int WRITE_TICKS  = 6,
  parameter int XFER_TICKS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              evt_raw,
  input  logic [TIME_W-1:0] load_time,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              clr,
  input  logic              lock,
  output logic [TIME_W-1:0] time_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              commit,
  output logic              busy
);
  localparam logic [TIME_W-1:0] TIME_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  evt_edge_t         ev;
  logic              rise_p, fall_p, inc_p;
  logic [TIME_W-1:0] time_d;
  logic [CNT_W-1:0]  count_d;
  logic              commit_q;

  evt_deglitch #(.GLITCH_TICKS(GLITCH_TICKS)) u_flt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(evt_raw), .ev(ev)
  );

  assign rise_p = ev.rise;
  assign fall_p = ev.fall;

  evt_pacer #(.START_TICKS(START_TICKS), .INCR_TICKS(INCR_TICKS)) u_pace (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(ev.level),
    .restart(rise_p), .inc(inc_p)
  );

  evt_busy #(.WRITE_TICKS(WRITE_TICKS), .XFER_TICKS(XFER_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_xfer(rise_p),
    .start_write(fall_p), .busy(busy)
  );

  always_comb begin
    time_d  = time_q;
    count_d = count_q;
    if (rise_p) begin
      time_d  = load_time;
      count_d = load_count;
    end else if (clr && !lock) begin
      time_d  = '0;
      count_d = '0;
    end else begin
      if (inc_p && time_q != TIME_MAX)   time_d  = time_q + 1'b1;
      if (fall_p && count_q != CNT_MAX)  count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      count_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      time_q   <= time_d;
      count_q  <= count_d;
      commit_q <= fall_p;
    end
  end

  assign commit = commit_q;
endmodule

// File: rtl/evt_tally_chk.sv
module evt_tally_chk #(
  parameter int TW = 32,
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          lock,
  input logic [TW-1:0] time_q,
  input logic [CW-1:0] count_q,
  input logic          commit,
  input logic          busy,
  input logic          rise_p,
  input logic          fall_p,
  input logic          inc_p
);
  assert_time_moves_on_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_p || rise_p || clr) |=> $stable(time_q));

  assert_count_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_p || rise_p || clr) |=> $stable(count_q));

  assert_time_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q == '1 && !rise_p && !clr) |=> time_q == '1);

  assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '1 && !rise_p && !clr) |=> count_q == '1);

  assert_commit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  assert_commit_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(fall_p));

  assert_busy_on_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !lock && !rise_p) |=> (time_q == '0 && count_q == '0));
endmodule

bind evt_tally evt_tally_chk #(.TW(TIME_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .lock(lock), .time_q(time_q),
  .count_q(count_q), .commit(commit), .busy(busy), .rise_p(rise_p),
  .fall_p(fall_p), .inc_p(inc_p)
);

// File: tb/evt_tally_test.sv
module evt_tally_test;
  localparam int G = 4, S = 5, I = 10, W = 6, X = 2;

  logic        clk, rst_n, tick, evt_raw, clr, lock;
  logic [31:0] load_time, time_q;
  logic [16:0] load_count, count_q;
  logic        commit, busy;
  logic [2:0]  tdiv;

  int nchk = 0, nfail = 0, commits = 0, busy_ticks = 0;
  logic [31:0] exp_t;
  logic [16:0] exp_c;

  evt_tally #(.GLITCH_TICKS(G), .START_TICKS(S), .INCR_TICKS(I),
              .WRITE_TICKS(W), .XFER_TICKS(X)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_raw(evt_raw),
    .load_time(load_time), .load_count(load_count), .clr(clr), .lock(lock),
    .time_q(time_q), .count_q(count_q), .commit(commit), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin tdiv <= '0; tick <= 1'b0; end
    else begin tdiv <= tdiv + 3'd1; tick <= (tdiv == 3'd6); end
  end

  always @(negedge clk) begin
    if (commit) commits++;
    if (tick && busy) busy_ticks++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_incs(input int h);
    return (h < S) ? 0 : 1 + (h - S) / I;
  endfunction

  function automatic logic [31:0] sat_t(input logic [31:0] b, input int n);
    logic [32:0] s = {1'b0, b} + 33'(n);
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  function automatic logic [16:0] sat_c(input logic [16:0] b);
    return (b == 17'h1FFFF) ? b : b + 17'd1;
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_event(input int h, input logic [31:0] lt, input logic [16:0] lc,
                           input string treq, input string creq);
    load_time = lt; load_count = lc; commits = 0; busy_ticks = 0;
    evt_raw = 1'b1;
    if (h >= G + 1) begin
      wait_ticks(G + 1);
      chk("R2", time_q, lt);
      chk("R2", {15'd0, count_q}, {15'd0, lc});
      wait_ticks(h - G - 1);
    end else begin
      wait_ticks(h);
    end
    evt_raw = 1'b0;
    wait_ticks(G + W + 3);
    if (h >= G) begin
      exp_t = sat_t(lt, exp_incs(h));
      exp_c = sat_c(lc);
      chk(treq, time_q, exp_t);
      chk(creq, {15'd0, count_q}, {15'd0, exp_c});
      chk("R8", commits, 1);
      chk("R9", busy_ticks, X + W);
    end else begin
      chk("R1", time_q, exp_t);
      chk("R1", {15'd0, count_q}, {15'd0, exp_c});
      chk("R1", commits, 0);
      chk("R1", busy_ticks, 0);
    end
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_raw = 1'b0; clr = 1'b0; lock = 1'b0;
    load_time = '0; load_count = '0;
    exp_t = '0; exp_c = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_ticks(2);
    // R11 reset state
    chk("R11", time_q, 0);
    chk("R11", {15'd0, count_q}, 0);
    chk("R11", {31'd0, commit}, 0);
    chk("R11", {31'd0, busy}, 0);

    // R4 short events and R3 boundary lengths
    run_event(G, 32'd100, 17'd7, "R4", "R5");
    run_event(S - 1, 32'd100, 17'd8, "R4", "R5");
    run_event(S, 32'd100, 17'd9, "R3", "R5");
    run_event(S + I - 1, 32'd200, 17'd9, "R3", "R5");
    run_event(S + I, 32'd200, 17'd9, "R3", "R5");
    // R1 glitch shorter than the filter
    run_event(G - 1, 32'd5, 17'd5, "R1", "R1");
    run_event(1, 32'd5, 17'd5, "R1", "R1");
    // R6 and R7 saturation
    run_event(30, 32'hFFFF_FFFE, 17'h1FFFE, "R6", "R5");
    run_event(12, 32'hFFFF_FFFF, 17'h1FFFF, "R6", "R7");

    // R10 clear with lock high, then low
    lock = 1'b1; clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    chk("R10", time_q, exp_t);
    chk("R10", {15'd0, count_q}, {15'd0, exp_c});
    lock = 1'b0; clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    chk("R10", time_q, 0);
    chk("R10", {15'd0, count_q}, 0);
    exp_t = '0; exp_c = '0;

    // constrained random events mixed with glitches
    for (int k = 0; k < 24; k++) begin
      int h;
      logic [31:0] lt;
      logic [16:0] lc;
      h  = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, G - 1))
                                        : int'($urandom_range(G, 55));
      lt = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFF0 + $urandom_range(0, 15) : $urandom;
      lc = 17'($urandom_range(0, 17'h1FFFF));
      run_event(h, lt, lc, (h < S) ? "R4" : "R3", "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule